// File: doc/BRIEF.md
# Inter-Processor Interrupt Send Router

This block takes a 32-bit send command from a shared request port and turns it into a status-set write aimed at one core's interrupt register bank. The command word packs a destination core number and an interrupt vector number. The router pulls out both fields and checks that the destination exists. It then drives a one-cycle set strobe toward that core alone, together with a one-hot word that has the bit of the chosen vector set. The receiving core bank treats this exactly like a write to its own set register, so its normal interrupt raise rule applies unchanged.

A destination number at or beyond the supported core count is refused. So is a destination inside that range whose core is marked as not populated. A refused command raises a decode-error flag in the same cycle it is presented, and it produces no strobe.

The core count is a parameter. The populated set of cores is given as a per-core presence vector.

Top module: `ipi_send_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no set strobe is active and the set data word is zero.
- R2: For an accepted command, the destination core is command bits 25:16, read as an unsigned 10-bit number. The set strobe bit with that index is raised in the cycle after the command is presented.
- R3: For an accepted command, the vector is command bits 4:0. In the strobe cycle the set data word equals 1 shifted left by that vector, for every vector from 0 to 31.
- R4: A valid command whose destination number is greater than or equal to MAX_CORES raises cmd_err combinationally in the same cycle, and no strobe follows.
- R5: A valid command whose destination is below MAX_CORES but whose bit in core_present is 0 raises cmd_err in the same cycle, and no strobe follows.
- R6: At most one set strobe bit is active in any cycle. Each accepted command produces a strobe that lasts exactly one cycle.
- R7: cmd_err is low whenever cmd_valid is low, and low for an accepted command.
- R8: Command bits 31:26 and 15:5 have no effect on cmd_err, set_strobe or set_data.
- R9: A cycle without cmd_valid, or with a refused command, leaves all strobes low and set_data zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A send command is presented this cycle |
| cmd_word | input | 32 | Send command: destination in 25:16, vector in 4:0 |
| core_present | input | MAX_CORES | Per-core populated flag |
| cmd_err | output | 1 | Decode error for the presented command, same cycle |
| set_strobe | output | MAX_CORES | One-cycle set-write strobe, one bit per core |
| set_data | output | 32 | One-hot set value that goes with the strobe |

## Verification
The hardest case to reach from the ports is a destination that is inside the supported range but not populated. A fully populated presence vector hides this case completely. The stimulus therefore swaps in presence masks with holes at the lowest and highest core numbers, and then sends commands to exactly those holes and to their neighbours. Random commands are kept mostly in range, with junk in the unused bits. A directed sweep covers all 32 vectors and the destinations MAX_CORES-1, MAX_CORES and 1023.

// File: rtl/ipi_route_pkg.sv
package ipi_route_pkg;

    localparam int CMD_W   = 32;
    localparam int TGT_LSB = 16;
    localparam int TGT_W   = 10;
    localparam int VEC_LSB = 0;
    localparam int VEC_W   = 5;
    localparam int VEC_SPACE = 1 << VEC_W;

    typedef logic [TGT_W-1:0]     tgt_t;
    typedef logic [VEC_W-1:0]     vec_t;
    typedef logic [VEC_SPACE-1:0] vec_mask_t;

    typedef struct packed {
        logic valid;
        tgt_t tgt;
        vec_t vec;
    } send_req_t;

    typedef enum logic [1:0] {
        DEC_IDLE   = 2'd0,
        DEC_OK     = 2'd1,
        DEC_RANGE  = 2'd2,
        DEC_ABSENT = 2'd3
    } dec_result_t;

    function automatic send_req_t unpack_cmd(input logic valid, input logic [CMD_W-1:0] w);
        send_req_t r;
        r.valid = valid;
        r.tgt   = w[TGT_LSB +: TGT_W];
        r.vec   = w[VEC_LSB +: VEC_W];
        return r;
    endfunction

    function automatic logic is_refused(input dec_result_t d);
        return (d == DEC_RANGE) || (d == DEC_ABSENT);
    endfunction

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_route_pkg::*;
#(
    parameter int MAX_CORES = 16,
    localparam int SEL_W = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1,
    localparam int PAD_N = 1 << SEL_W
) (
    input  logic                 valid,
    input  logic [CMD_W-1:0]     cmd,
    input  logic [MAX_CORES-1:0] present,
    output send_req_t            req,
    output dec_result_t          result,
    output logic [SEL_W-1:0]     sel_idx
);

    logic [PAD_N-1:0] present_pad;
    logic             out_of_range;
    logic             populated;

    assign req          = unpack_cmd(valid, cmd);
    assign present_pad  = PAD_N'(present);
    assign out_of_range = ({22'd0, req.tgt} >= 32'(MAX_CORES));
    assign sel_idx      = req.tgt[SEL_W-1:0];
    assign populated    = present_pad[sel_idx];

    always_comb begin
        if (!req.valid)
            result = DEC_IDLE;
        else if (out_of_range)
            result = DEC_RANGE;
        else if (!populated)
            result = DEC_ABSENT;
        else
            result = DEC_OK;
    end

endmodule

// File: rtl/ipi_vec_onehot.sv
module ipi_vec_onehot
    import ipi_route_pkg::*;
(
    input  vec_t      vec,
    output vec_mask_t mask
);

    for (genvar i = 0; i < VEC_SPACE; i++) begin : g_bit
        assign mask[i] = (vec == VEC_W'(i));
    end

endmodule

// File: rtl/ipi_core_strobe.sv
module ipi_core_strobe
    import ipi_route_pkg::*;
#(
    parameter int MAX_CORES = 16,
    localparam int SEL_W = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  logic [SEL_W-1:0]     sel_idx,
    input  vec_mask_t            mask,
    output logic [MAX_CORES-1:0] strobe,
    output vec_mask_t            data
);

    for (genvar c = 0; c < MAX_CORES; c++) begin : g_core
        always_ff @(posedge clk) begin
            if (rst)
                strobe[c] <= 1'b0;
            else
                strobe[c] <= fire && (sel_idx == SEL_W'(c));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            data <= '0;
        else if (fire)
            data <= mask;
        else
            data <= '0;
    end

endmodule

// File: rtl/ipi_send_router.sv
module ipi_send_router
    import ipi_route_pkg::*;
#(
    parameter int MAX_CORES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [31:0]          cmd_word,
    input  logic [MAX_CORES-1:0] core_present,
    output logic                 cmd_err,
    output logic [MAX_CORES-1:0] set_strobe,
    output logic [31:0]          set_data
);

    localparam int SEL_W = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1;

    send_req_t        req;
    dec_result_t      result;
    logic [SEL_W-1:0] sel_idx;
    vec_mask_t        mask;
    logic             fire;

    ipi_cmd_decode #(.MAX_CORES(MAX_CORES)) u_decode (
        .valid   (cmd_valid),
        .cmd     (cmd_word),
        .present (core_present),
        .req     (req),
        .result  (result),
        .sel_idx (sel_idx)
    );

    ipi_vec_onehot u_onehot (
        .vec  (req.vec),
        .mask (mask)
    );

    assign fire    = (result == DEC_OK);
    assign cmd_err = is_refused(result);

    ipi_core_strobe #(.MAX_CORES(MAX_CORES)) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .sel_idx (sel_idx),
        .mask    (mask),
        .strobe  (set_strobe),
        .data    (set_data)
    );

endmodule

// File: rtl/ipi_send_router_chk.sv
module ipi_send_router_chk #(
    parameter int MAX_CORES = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [31:0]          cmd_word,
    input logic [MAX_CORES-1:0] core_present,
    input logic                 cmd_err,
    input logic [MAX_CORES-1:0] set_strobe,
    input logic [31:0]          set_data
);

    p_strobe_onehot0_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_strobe));

    p_data_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        (set_strobe != '0) |-> ($countones(set_data) == 1));

    p_range_err_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ({22'd0, cmd_word[25:16]} >= 32'(MAX_CORES))) |-> cmd_err);

    p_err_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_err) |=> (set_strobe == '0));

    p_idle_no_err_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> !cmd_err);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (set_strobe == '0 && set_data == '0));

    p_accept_fires_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_err) |=> (set_strobe != '0));

endmodule

bind ipi_send_router ipi_send_router_chk #(.MAX_CORES(MAX_CORES)) u_chk (.*);

// File: tb/ipi_send_router_bench.sv
module ipi_send_router_bench;

    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid;
    logic [31:0]   cmd_word;
    logic [NC-1:0] core_present;
    logic          cmd_err;
    logic [NC-1:0] set_strobe;
    logic [31:0]   set_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ipi_send_router #(.MAX_CORES(NC)) u_ipi_send_router (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .core_present(core_present), .cmd_err(cmd_err),
        .set_strobe(set_strobe), .set_data(set_data)
    );

    function automatic bit exp_err(bit v, logic [31:0] w, logic [NC-1:0] pres);
        int t = int'(w[25:16]);
        if (!v) return 1'b0;
        if (t >= NC) return 1'b1;
        return !pres[t];
    endfunction

    function automatic logic [NC-1:0] exp_strobe(bit v, logic [31:0] w, logic [NC-1:0] pres);
        if (!v || exp_err(v, w, pres)) return '0;
        return NC'(1) << w[25:16];
    endfunction

    function automatic logic [31:0] exp_data(bit v, logic [31:0] w, logic [NC-1:0] pres);
        if (!v || exp_err(v, w, pres)) return '0;
        return 32'd1 << w[4:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Call at a falling edge; returns at the next falling edge after checking.
    task automatic apply(string req, bit v, logic [31:0] w);
        cmd_valid = v;
        cmd_word  = w;
        #1;
        check({req, " err"}, 32'(cmd_err), 32'(exp_err(v, w, core_present)));
        @(negedge clk);
        check({req, " strobe"}, 32'(set_strobe), 32'(exp_strobe(v, w, core_present)));
        check({req, " data"}, set_data, exp_data(v, w, core_present));
        cmd_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk(int tgt, int vec);
        return {6'd0, 10'(tgt), 11'd0, 5'(vec)};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        cmd_valid = 1'b0;
        cmd_word = '0;
        core_present = '1;
        repeat (3) @(negedge clk);
        // R1: reset state, valid held high during reset
        cmd_valid = 1'b1;
        cmd_word = mk(3, 7);
        #1;
        check("R1 strobe in reset", 32'(set_strobe), 32'd0);
        check("R1 data in reset", set_data, 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 strobe after reset", 32'(set_strobe), 32'd0);
        check("R1 data after reset", set_data, 32'd0);

        // R2 boundary cores, R4 out of range
        apply("R2 core0", 1'b1, mk(0, 1));
        apply("R2 core max-1", 1'b1, mk(NC - 1, 2));
        apply("R4 core max", 1'b1, mk(NC, 3));
        apply("R4 core 1023", 1'b1, mk(1023, 31));
        apply("R4 core 512", 1'b1, mk(512, 0));
        // R3: every vector
        for (int v = 0; v < 32; v++) apply("R3 vector sweep", 1'b1, mk(NC - 1, v));
        // R6: back-to-back, then strobe must drop
        apply("R6 b2b a", 1'b1, mk(5, 9));
        apply("R6 b2b b", 1'b1, mk(6, 10));
        apply("R6 drop", 1'b0, mk(6, 10));
        // R9 / R7: idle with garbage on the bus
        apply("R9 idle", 1'b0, 32'hFFFF_FFFF);
        // R8: junk in unused bits
        apply("R8 junk", 1'b1, mk(4, 12) | 32'hFC00_FFE0);
        apply("R8 junk2", 1'b1, mk(NC - 1, 0) | 32'h5400_AA40);
        // R5: holes at lowest and highest core
        core_present = '1;
        core_present[0] = 1'b0;
        core_present[NC - 1] = 1'b0;
        apply("R5 hole low", 1'b1, mk(0, 4));
        apply("R5 hole high", 1'b1, mk(NC - 1, 4));
        apply("R5 neighbour low", 1'b1, mk(1, 5));
        apply("R5 neighbour high", 1'b1, mk(NC - 2, 6));
        apply("R9 after refuse", 1'b0, '0);

        // random
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            bit v;
            core_present = NC'($urandom) | NC'($urandom);
            w = $urandom;
            if ($urandom_range(0, 3) != 0) w[25:16] = 10'($urandom_range(0, NC - 1));
            v = ($urandom_range(0, 4) != 0);
            apply(v ? "R2 R3 R5 random" : "R7 R9 random idle", v, w);
        end
        finish_run();
    end

endmodule